// File: doc/BRIEF.md
# Frame Decode Enable Counter Bank

This block decides whether a paging decoder has to decode every frame, and not only the frames assigned to it. It holds one small counter for each temporary address and one counter for fragmented messages. Internal receive events raise these counters. Host commands lower them. A sticky force flag, also written by the host, sits beside them. Whenever any counter is nonzero or the flag is set, the all-frame enable is high. While it is high, the block requests an end-of-frame status report after each frame boundary.

The host sends 32-bit command words. A word counts as a command for this block only if its identifier field matches. A matching word can do three things at once: lower the fragmented-message counter, lower any chosen set of temporary-address counters, and set or clear the force flag. The counters saturate at both ends and never wrap. Switching the decoder off clears the whole bank, as reset does.

Top module: `frame_enable_bank`

## Requirements
- R1: After reset, `afm_en_o` and `eof_req_o` are 0, all counters are 0 and the force flag is clear.
- R2: A command word with `cmd_valid_i` high is accepted only when bits [29:24] equal 3. Any other value in that field changes no counter and leaves the force flag unchanged.
- R3: The pulse `ta_inc_valid_i` with `ta_inc_idx_i` = i raises temporary-address counter i by one. In an accepted command, bit 8+i lowers counter i by one, for i from 0 to 15 (bits [23:8]). Bits [7:0] are ignored.
- R4: A high `af_inc_i` raises the fragmented-message counter by one. In an accepted command, bit 31 lowers it by one.
- R5: Each accepted command loads the force flag from bit 30: 1 sets it and 0 clears it.
- R6: `afm_en_o` is high exactly when any counter is nonzero or the force flag is set. It follows the clock edge that updates that state.
- R7: No counter goes past 127. A raise at 127 leaves the counter at 127.
- R8: No counter goes below 0. A lowering at 0 leaves the counter at 0.
- R9: If a raise and a lowering reach the same counter in the same cycle, the counter keeps its value.
- R10: While `dec_on_i` is low, all counters and the force flag are held at 0, and raise events and commands are ignored.
- R11: `eof_req_o` is high for the one cycle after a cycle in which `frame_end_i`, `afm_en_o` and `dec_on_i` are all high. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_on_i | input | 1 | Decoder on; low clears the bank |
| cmd_valid_i | input | 1 | Host command word strobe |
| cmd_word_i | input | 32 | Host command word |
| ta_inc_valid_i | input | 1 | Temporary-address assignment event |
| ta_inc_idx_i | input | 4 | Temporary address being assigned |
| af_inc_i | input | 1 | Fragmented-message vector event |
| frame_end_i | input | 1 | End-of-frame strobe |
| afm_en_o | output | 1 | All-frame decoding enable |
| eof_req_o | output | 1 | End-of-frame status request |

## Verification
The bench drives the fragmented-message counter up 130 times and then down 127 times. A counter that wrapped or counted past 127 would drop the enable too early or too late. It lowers a counter that is already 0, and it raises and lowers a counter in the same cycle while that counter is at 0. Either error, whether wrapping to 127 or applying the raise after the clamp, would leave the enable stuck high. Further checks lower neighbouring temporary addresses and send words with a wrong identifier. These catch a misrouted bit map or an accepted foreign packet, because the enable would clear early or the force flag would change. A final set of checks confirms that decoder-off wipes both the counters and the flag, and that the status request depends on the enable in the frame-end cycle.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int          CMD_W       = 32;
  localparam int          ID_HI       = 29;
  localparam int          ID_LO       = 24;
  localparam int          ID_W        = ID_HI - ID_LO + 1;
  localparam logic [ID_W-1:0] PKT_ID  = ID_W'(3);
  localparam int          AF_DEC_BIT  = 31;
  localparam int          FORCE_BIT   = 30;
  localparam int          TA_LO       = 8;
  localparam int          TA_MAX      = 16;

  typedef struct packed {
    logic               hit;
    logic               af_dec;
    logic               force_val;
    logic [TA_MAX-1:0]  ta_dec;
  } fe_cmd_t;
endpackage

// File: rtl/fe_cmd_dec.sv
module fe_cmd_dec
  import fe_pkg::*;
(
  input  logic             valid_i,
  input  logic [CMD_W-1:0] word_i,
  output fe_cmd_t          cmd_o
);
  always_comb begin
    cmd_o.hit       = valid_i && (word_i[ID_HI:ID_LO] == PKT_ID);
    cmd_o.af_dec    = cmd_o.hit && word_i[AF_DEC_BIT];
    cmd_o.force_val = word_i[FORCE_BIT];
    cmd_o.ta_dec    = cmd_o.hit ? word_i[TA_LO +: TA_MAX] : '0;
  end
endmodule

// File: rtl/fe_sat_cnt.sv
module fe_sat_cnt #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         nz_o
);
  localparam logic [W-1:0] MaxVal = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (clr_i)                          cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != MaxVal) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
  assign nz_o  = |cnt_q;
endmodule

// File: rtl/fe_eof_gen.sv
module fe_eof_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dec_on_i,
  input  logic frame_end_i,
  input  logic afm_en_i,
  output logic eof_req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= dec_on_i && frame_end_i && afm_en_i;
  end

  assign eof_req_o = req_q;
endmodule

// File: rtl/frame_enable_bank.sv
module frame_enable_bank
  import fe_pkg::*;
#(
  parameter int NUM_TA = 16,
  parameter int CNT_W  = 7,
  parameter int IDX_W  = $clog2(NUM_TA)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_on_i,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_word_i,
  input  logic             ta_inc_valid_i,
  input  logic [IDX_W-1:0] ta_inc_idx_i,
  input  logic             af_inc_i,
  input  logic             frame_end_i,
  output logic             afm_en_o,
  output logic             eof_req_o
);
  fe_cmd_t           cmd;
  logic [NUM_TA-1:0] ta_nz;
  logic              af_nz;
  logic [CNT_W-1:0]  af_cnt;
  logic              force_q;
  logic              clr;

  assign clr = !dec_on_i;

  fe_cmd_dec u_dec (
    .valid_i (cmd_valid_i),
    .word_i  (cmd_word_i),
    .cmd_o   (cmd)
  );

  for (genvar i = 0; i < NUM_TA; i++) begin : g_ta
    logic [CNT_W-1:0] cnt_unused;
    logic             ta_inc;
    assign ta_inc = ta_inc_valid_i && (ta_inc_idx_i == IDX_W'(i));
    fe_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .inc_i  (ta_inc),
      .dec_i  (cmd.ta_dec[i]),
      .cnt_o  (cnt_unused),
      .nz_o   (ta_nz[i])
    );
  end

  fe_sat_cnt #(.W(CNT_W)) u_af_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (af_inc_i),
    .dec_i  (cmd.af_dec),
    .cnt_o  (af_cnt),
    .nz_o   (af_nz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      force_q <= 1'b0;
    else if (clr)     force_q <= 1'b0;
    else if (cmd.hit) force_q <= cmd.force_val;
  end

  assign afm_en_o = force_q || af_nz || (|ta_nz);

  fe_eof_gen u_eof (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dec_on_i    (dec_on_i),
    .frame_end_i (frame_end_i),
    .afm_en_i    (afm_en_o),
    .eof_req_o   (eof_req_o)
  );
endmodule

module fe_bank_chk
  import fe_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dec_on_i,
  input logic             cmd_valid_i,
  input logic [CMD_W-1:0] cmd_word_i,
  input logic             ta_inc_valid_i,
  input logic             af_inc_i,
  input logic             frame_end_i,
  input logic             afm_en_o,
  input logic             eof_req_o,
  input logic [CNT_W-1:0] af_cnt
);
  logic id_ok, af_dec;
  assign id_ok  = cmd_valid_i && (cmd_word_i[ID_HI:ID_LO] == PKT_ID);
  assign af_dec = id_ok && cmd_word_i[AF_DEC_BIT];

  // R10
  dec_off_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_on_i |=> !afm_en_o);
  // R5
  force_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_on_i && id_ok && cmd_word_i[FORCE_BIT]) |=> afm_en_o);
  // R2
  bad_id_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_on_i && cmd_valid_i && !id_ok && !ta_inc_valid_i && !af_inc_i) |=> $stable(afm_en_o));
  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_on_i && af_cnt == {CNT_W{1'b1}} && af_inc_i && !af_dec) |=> af_cnt == {CNT_W{1'b1}});
  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (af_cnt == '0 && !af_inc_i) |=> af_cnt == '0);
  // R11
  eof_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_on_i && frame_end_i && afm_en_o) |=> eof_req_o);
  // R11
  eof_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> !eof_req_o);
endmodule

bind frame_enable_bank fe_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .dec_on_i       (dec_on_i),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_word_i     (cmd_word_i),
  .ta_inc_valid_i (ta_inc_valid_i),
  .af_inc_i       (af_inc_i),
  .frame_end_i    (frame_end_i),
  .afm_en_o       (afm_en_o),
  .eof_req_o      (eof_req_o),
  .af_cnt         (af_cnt)
);

// File: tb/frame_enable_bank_bench.sv
module frame_enable_bank_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dec_on_i = 1'b1;
  logic        cmd_valid_i = 1'b0;
  logic [31:0] cmd_word_i = '0;
  logic        ta_inc_valid_i = 1'b0;
  logic [3:0]  ta_inc_idx_i = '0;
  logic        af_inc_i = 1'b0;
  logic        frame_end_i = 1'b0;
  logic        afm_en_o, eof_req_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  frame_enable_bank u_frame_enable_bank (.*);

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit af, bit frc, logic [15:0] ta, logic [5:0] id = 6'd3);
    return {af, frc, id, ta, 8'h00};
  endfunction

  task automatic send(logic [31:0] w);
    cmd_valid_i = 1'b1; cmd_word_i = w;
    step();
    cmd_valid_i = 1'b0; cmd_word_i = '0;
  endtask

  task automatic ta_inc(int idx);
    ta_inc_valid_i = 1'b1; ta_inc_idx_i = 4'(idx);
    step();
    ta_inc_valid_i = 1'b0;
  endtask

  task automatic af_inc();
    af_inc_i = 1'b1;
    step();
    af_inc_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 afm_en after reset", afm_en_o, 1'b0);
    chk("R1 eof_req after reset", eof_req_o, 1'b0);
  endtask

  task automatic t_ta_map();
    ta_inc(5); ta_inc(5);
    chk("R3 ta5 raised", afm_en_o, 1'b1);
    send(mk(0, 0, 16'h0020));
    chk("R3 ta5 at 1", afm_en_o, 1'b1);
    send(mk(0, 0, 16'h0040));
    chk("R3 ta6 lower leaves ta5", afm_en_o, 1'b1);
    send(mk(0, 0, 16'h0020));
    chk("R3 ta5 back to 0", afm_en_o, 1'b0);
    ta_inc(15); ta_inc(0);
    send(mk(0, 0, 16'h8000));
    chk("R3 ta0 still held", afm_en_o, 1'b1);
    send(mk(0, 0, 16'h0001));
    chk("R3 ta0 and ta15 cleared", afm_en_o, 1'b0);
  endtask

  task automatic t_af();
    af_inc();
    chk("R4 af raised", afm_en_o, 1'b1);
    send(mk(1, 0, 16'h0000));
    chk("R4 af lowered", afm_en_o, 1'b0);
  endtask

  task automatic t_force();
    send(mk(0, 1, 16'h0000));
    chk("R5 force set", afm_en_o, 1'b1);
    send(mk(0, 1, 16'h0000));
    chk("R6 force held", afm_en_o, 1'b1);
    send(mk(0, 0, 16'h0000));
    chk("R5 force cleared", afm_en_o, 1'b0);
  endtask

  task automatic t_bad_id();
    send(mk(0, 1, 16'h0000, 6'd2));
    chk("R2 bad id no force", afm_en_o, 1'b0);
    af_inc();
    send(mk(1, 0, 16'h0000, 6'd7));
    chk("R2 bad id no lower", afm_en_o, 1'b1);
    send(mk(0, 1, 16'h0000));
    send(mk(1, 0, 16'h0000, 6'd35));
    chk("R2 bad id keeps force", afm_en_o, 1'b1);
    send(mk(1, 0, 16'h0000));
    chk("R4 force clear and af lower", afm_en_o, 1'b0);
  endtask

  task automatic t_sat_hi();
    for (int i = 0; i < 130; i++) af_inc();
    for (int i = 0; i < 126; i++) send(mk(1, 0, 16'h0000));
    chk("R7 count 1 after saturating", afm_en_o, 1'b1);
    send(mk(1, 0, 16'h0000));
    chk("R7 count 0 after 127 lowers", afm_en_o, 1'b0);
  endtask

  task automatic t_sat_lo();
    send(mk(1, 0, 16'hFFFF));
    chk("R8 lower at 0 stays 0", afm_en_o, 1'b0);
    ta_inc(9);
    send(mk(0, 0, 16'h0200));
    chk("R8 single raise undone", afm_en_o, 1'b0);
  endtask

  task automatic t_same_cycle();
    af_inc_i = 1'b1;
    send(mk(1, 0, 16'h0000));
    af_inc_i = 1'b0;
    chk("R9 af raise+lower at 0 holds", afm_en_o, 1'b0);
    ta_inc_valid_i = 1'b1; ta_inc_idx_i = 4'd3;
    send(mk(0, 0, 16'h0008));
    ta_inc_valid_i = 1'b0;
    chk("R9 ta3 raise+lower at 0 holds", afm_en_o, 1'b0);
  endtask

  task automatic t_dec_off();
    af_inc(); ta_inc(2);
    send(mk(0, 1, 16'h0000));
    dec_on_i = 1'b0;
    step();
    chk("R10 off clears bank", afm_en_o, 1'b0);
    af_inc(); ta_inc(2);
    send(mk(0, 1, 16'h0000));
    chk("R10 events ignored while off", afm_en_o, 1'b0);
    dec_on_i = 1'b1;
    step();
    chk("R10 still clear after on", afm_en_o, 1'b0);
  endtask

  task automatic t_eof();
    frame_end_i = 1'b1; step(); frame_end_i = 1'b0;
    chk("R11 no request when idle", eof_req_o, 1'b0);
    send(mk(0, 1, 16'h0000));
    frame_end_i = 1'b1; step(); frame_end_i = 1'b0;
    chk("R11 request after frame end", eof_req_o, 1'b1);
    step();
    chk("R11 request is one cycle", eof_req_o, 1'b0);
    send(mk(0, 0, 16'h0000));
    chk("R6 enable drops", afm_en_o, 1'b0);
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_ta_map();
    t_af();
    t_force();
    t_bad_id();
    t_sat_hi();
    t_sat_lo();
    t_same_cycle();
    t_dec_off();
    t_eof();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule